// File: doc/BRIEF.md
# Latched Fault Flag Encoder

This block gathers fault conditions from the primary side of an isolated half-bridge gate driver and from each secondary-side driver channel. The primary conditions are supply undervoltage, supply overvoltage and overtemperature. Each channel reports supply undervoltage, supply overvoltage and overcurrent. The block folds them into a two-bit latched fault code that a host controller can read at any time. It also drives a per-channel inhibit that tells the PWM path to drop or refuse gate pulses.

How a flag behaves depends on where its fault comes from. A primary flag cannot be cleared while its condition is present, and after the condition goes away it stays set until the host clears it. A secondary supply flag is raised only when a PWM transmission is attempted on that channel while the condition exists. The host can clear it, and it returns on the next attempt if the fault is still there. An overcurrent event raises its flag at once, with no link to PWM timing. The same event also blocks its channel for the rest of the current PWM cycle. A primary fault stops both channels, and a secondary fault stops only its own channel. A host clear pulse and a restart level both clear the latched flags. Restart also ends any overcurrent cycle block.

Top module: `fault_flag_encoder`

## Requirements
- R1: Each latched source adds a code to `flag_code`, where bit 1 is the first fault line and bit 0 is the second. Undervoltage (primary or secondary) adds 2'b10. Overvoltage (primary or secondary) adds 2'b01. Overtemperature adds 2'b11. Overcurrent adds 2'b01. With several sources latched, the output is the bitwise OR of their codes.
- R2: A primary flag sets whenever its condition is high in a sampled cycle. A clear request does not remove it while the condition is still high. Once the condition is low, the flag stays set until a clear request arrives.
- R3: A `flag_clr` pulse removes every latched flag that is not set again in the same cycle. If a set and a clear fall in the same cycle, the flag stays set.
- R4: A channel's secondary supply flag sets only in a cycle where that channel's `pwm_req` is high while its `sec_uv` or `sec_ov` is high. A condition with no request leaves the flag unchanged.
- R5: An overcurrent event on a channel sets the overcurrent flag in that cycle, whatever the PWM timing. A clear removes the flag, and a later event sets it again.
- R6: While any primary condition is high, both bits of `pwm_inhibit` are high.
- R7: A secondary supply condition on a channel sets only that channel's `pwm_inhibit` bit.
- R8: An overcurrent event holds its channel's inhibit high until the next `pwm_req` on that channel. If an event and a request arrive in the same cycle, the block stays in place. A host clear does not end the block.
- R9: A high `restart` clears all latched flags and every overcurrent block, unless an event sets them again in the same cycle.
- R10: A synchronous active-high `rst` forces `flag_code` and `pwm_inhibit` to zero.
- R11: Both outputs are registered. A change on an input first shows at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_uv | input | 1 | Primary supply undervoltage condition (level) |
| pri_ov | input | 1 | Primary supply overvoltage condition (level) |
| pri_ot | input | 1 | Primary overtemperature condition (level) |
| sec_uv | input | NUM_CH | Per-channel secondary supply undervoltage condition (level) |
| sec_ov | input | NUM_CH | Per-channel secondary supply overvoltage condition (level) |
| oc_evt | input | NUM_CH | Per-channel overcurrent event (one-cycle pulse) |
| pwm_req | input | NUM_CH | Per-channel PWM transmission attempt / cycle start (pulse) |
| flag_clr | input | 1 | Host flag clear pulse |
| restart | input | 1 | Restart level; clears flags and overcurrent blocks |
| flag_code | output | 2 | Latched fault code; bit 1 first fault line, bit 0 second |
| pwm_inhibit | output | NUM_CH | Per-channel PWM inhibit |

## Verification
The bench builds the block with the default of two channels. That is the smallest setting in which it can be shown that a secondary fault or an overcurrent block on one channel leaves the other channel's inhibit low, while a primary condition raises both. Two channels also allow codes from different sources on different channels to combine into 2'b11 within one cycle. The same-cycle set-versus-clear races for every flag kind are reachable at this setting.

// File: rtl/fault_enc_pkg.sv
package fault_enc_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;

  // bit 1 drives the first fault line, bit 0 the second
  localparam code_t CODE_UV = 2'b10;
  localparam code_t CODE_OV = 2'b01;
  localparam code_t CODE_OT = 2'b11;
  localparam code_t CODE_OC = 2'b01;
  localparam code_t CODE_NONE = 2'b00;

  function automatic code_t code_of(input logic uv, input logic ov,
                                    input logic ot, input logic oc);
    code_t c;
    c = CODE_NONE;
    if (uv) c = c | CODE_UV;
    if (ov) c = c | CODE_OV;
    if (ot) c = c | CODE_OT;
    if (oc) c = c | CODE_OC;
    return c;
  endfunction
endpackage

// File: rtl/fault_sticky.sv
// Bank of sticky flags: a set in the same cycle as a clear wins.
module fault_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_nxt_o
);
  logic [W-1:0] q;

  always_comb begin
    q_nxt_o = set_i | (q & ~{W{clr_i}});
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt_o;
  end
endmodule

// File: rtl/fault_channel.sv
// Per-channel secondary fault state: supply flags, overcurrent flag, cycle block.
module fault_channel
  import fault_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sec_uv,
  input  logic  sec_ov,
  input  logic  oc_evt,
  input  logic  pwm_req,
  input  logic  clr_any,
  input  logic  restart,
  output code_t code_nxt_o,
  output logic  inh_nxt_o
);
  logic [2:0] set_vec;
  logic [2:0] flag_nxt;
  logic       oc_block;
  logic       oc_block_nxt;

  // supply flags echo only on a transmission attempt
  assign set_vec = {oc_evt, pwm_req & sec_ov, pwm_req & sec_uv};

  fault_sticky #(.W(3)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .clr_i   (clr_any),
    .q_nxt_o (flag_nxt)
  );

  always_comb begin
    oc_block_nxt = oc_evt | (oc_block & ~pwm_req & ~restart);
  end

  always_ff @(posedge clk) begin
    if (rst) oc_block <= 1'b0;
    else     oc_block <= oc_block_nxt;
  end

  assign code_nxt_o = code_of(flag_nxt[0], flag_nxt[1], 1'b0, flag_nxt[2]);
  assign inh_nxt_o  = sec_uv | sec_ov | oc_block_nxt;
endmodule

// File: rtl/fault_code_merge.sv
// OR-combines all code contributions and inhibit terms into registered outputs.
module fault_code_merge
  import fault_enc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  code_t                        pri_code,
  input  logic [NUM_CH-1:0][CODE_W-1:0] ch_code,
  input  logic                         pri_halt,
  input  logic [NUM_CH-1:0]            ch_inh,
  output code_t                        flag_code,
  output logic [NUM_CH-1:0]            pwm_inhibit
);
  code_t              code_sum;
  logic [NUM_CH-1:0]  inh_sum;

  always_comb begin
    code_sum = pri_code;
    for (int i = 0; i < NUM_CH; i++) begin
      code_sum = code_sum | ch_code[i];
    end
    inh_sum = ch_inh | {NUM_CH{pri_halt}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_code   <= CODE_NONE;
      pwm_inhibit <= '0;
    end else begin
      flag_code   <= code_sum;
      pwm_inhibit <= inh_sum;
    end
  end
endmodule

// File: rtl/fault_flag_encoder.sv
module fault_flag_encoder
  import fault_enc_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pri_uv,
  input  logic              pri_ov,
  input  logic              pri_ot,
  input  logic [NUM_CH-1:0] sec_uv,
  input  logic [NUM_CH-1:0] sec_ov,
  input  logic [NUM_CH-1:0] oc_evt,
  input  logic [NUM_CH-1:0] pwm_req,
  input  logic              flag_clr,
  input  logic              restart,
  output logic [1:0]        flag_code,
  output logic [NUM_CH-1:0] pwm_inhibit
);
  logic                          clr_any;
  logic [2:0]                    pri_nxt;
  code_t                         pri_code;
  logic                          pri_halt;
  logic [NUM_CH-1:0][CODE_W-1:0] ch_code;
  logic [NUM_CH-1:0]             ch_inh;

  assign clr_any  = flag_clr | restart;
  assign pri_halt = pri_uv | pri_ov | pri_ot;

  // primary flags: a live condition re-sets every cycle, so it cannot be cleared
  fault_sticky #(.W(3)) u_pri (
    .clk     (clk),
    .rst     (rst),
    .set_i   ({pri_ot, pri_ov, pri_uv}),
    .clr_i   (clr_any),
    .q_nxt_o (pri_nxt)
  );

  assign pri_code = code_of(pri_nxt[0], pri_nxt[1], pri_nxt[2], 1'b0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fault_channel u_ch (
      .clk        (clk),
      .rst        (rst),
      .sec_uv     (sec_uv[g]),
      .sec_ov     (sec_ov[g]),
      .oc_evt     (oc_evt[g]),
      .pwm_req    (pwm_req[g]),
      .clr_any    (clr_any),
      .restart    (restart),
      .code_nxt_o (ch_code[g]),
      .inh_nxt_o  (ch_inh[g])
    );
  end

  fault_code_merge #(.NUM_CH(NUM_CH)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .pri_code    (pri_code),
    .ch_code     (ch_code),
    .pri_halt    (pri_halt),
    .ch_inh      (ch_inh),
    .flag_code   (flag_code),
    .pwm_inhibit (pwm_inhibit)
  );
endmodule

// File: rtl/fault_flag_encoder_chk.sv
module fault_flag_encoder_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pri_uv,
  input logic              pri_ov,
  input logic              pri_ot,
  input logic [NUM_CH-1:0] sec_uv,
  input logic [NUM_CH-1:0] sec_ov,
  input logic [NUM_CH-1:0] oc_evt,
  input logic [NUM_CH-1:0] pwm_req,
  input logic              flag_clr,
  input logic              restart,
  input logic [1:0]        flag_code,
  input logic [NUM_CH-1:0] pwm_inhibit
);
  logic no_event;
  assign no_event = !(pri_uv || pri_ov || pri_ot) && !(|oc_evt) && !(|pwm_req);

  AST_PRI_UV_CODE: assert property (@(posedge clk) disable iff (rst)
    pri_uv |=> flag_code[1]); // R2
  AST_PRI_OV_CODE: assert property (@(posedge clk) disable iff (rst)
    pri_ov |=> flag_code[0]); // R1
  AST_PRI_OT_CODE: assert property (@(posedge clk) disable iff (rst)
    pri_ot |=> (flag_code == 2'b11)); // R1
  AST_PRI_HALT_ALL: assert property (@(posedge clk) disable iff (rst)
    (pri_uv || pri_ov || pri_ot) |=> (&pwm_inhibit)); // R6
  AST_SEC_UV_ECHO: assert property (@(posedge clk) disable iff (rst)
    (|(pwm_req & sec_uv)) |=> flag_code[1]); // R4
  AST_OC_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|oc_evt) |=> flag_code[0]); // R5
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((flag_clr || restart) && no_event) |=> (flag_code == 2'b00)); // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_code[1] && !flag_clr && !restart) |=> flag_code[1]); // R2
  AST_RESTART_UNBLOCK: assert property (@(posedge clk) disable iff (rst)
    (restart && no_event && !(|sec_uv) && !(|sec_ov)) |=> (pwm_inhibit == '0)); // R9
endmodule

bind fault_flag_encoder fault_flag_encoder_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pri_uv      (pri_uv),
  .pri_ov      (pri_ov),
  .pri_ot      (pri_ot),
  .sec_uv      (sec_uv),
  .sec_ov      (sec_ov),
  .oc_evt      (oc_evt),
  .pwm_req     (pwm_req),
  .flag_clr    (flag_clr),
  .restart     (restart),
  .flag_code   (flag_code),
  .pwm_inhibit (pwm_inhibit)
);

// File: tb/fault_flag_encoder_tb.sv
module fault_flag_encoder_tb;
  localparam int NUM_CH = 2;
  localparam int NVEC   = 26;

  logic clk = 1'b0;
  logic rst;
  logic pri_uv, pri_ov, pri_ot;
  logic [NUM_CH-1:0] sec_uv, sec_ov, oc_evt, pwm_req;
  logic flag_clr, restart;
  logic [1:0] flag_code;
  logic [NUM_CH-1:0] pwm_inhibit;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fault_flag_encoder #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rst(rst), .pri_uv(pri_uv), .pri_ov(pri_ov), .pri_ot(pri_ot),
    .sec_uv(sec_uv), .sec_ov(sec_ov), .oc_evt(oc_evt), .pwm_req(pwm_req),
    .flag_clr(flag_clr), .restart(restart),
    .flag_code(flag_code), .pwm_inhibit(pwm_inhibit)
  );

  // {pu,po,pt, su[1:0], so[1:0], oc[1:0], rq[1:0], clr,rst, exp_code, exp_inh, req_no}
  localparam logic [20:0] VEC [NVEC] = '{
    21'b000_00_00_00_00_00_00_00_0001, // R1 idle
    21'b100_00_00_00_00_00_10_11_0110, // R6 primary uv halts both, code 10
    21'b100_00_00_00_00_10_10_11_0010, // R2 clear blocked while uv present
    21'b000_00_00_00_00_00_10_00_0010, // R2 flag held after condition gone
    21'b000_00_00_00_00_10_00_00_0011, // R3 clear removes it
    21'b010_00_00_00_00_00_01_11_0001, // R1 primary ov code 01
    21'b001_00_00_00_00_00_11_11_0001, // R1 ot code 11 OR held ov
    21'b000_00_00_00_00_10_00_00_0011, // R3 clear
    21'b000_01_00_00_00_00_00_01_0100, // R4 no request: no flag, ch0 inhibited
    21'b000_01_00_00_01_00_10_01_0100, // R4 request echoes uv
    21'b000_01_00_00_00_10_00_01_0100, // R4 clearable while condition present
    21'b000_01_00_00_01_00_10_01_0111, // R7 echo again, only ch0 inhibited
    21'b000_00_00_00_00_10_00_00_0011, // R3 clear
    21'b000_00_10_00_10_00_01_10_0111, // R7 ch1 ov, only ch1 inhibited
    21'b000_00_10_00_10_10_01_10_0011, // R3 set beats clear
    21'b000_00_00_00_00_01_00_00_1001, // R9 restart clears
    21'b000_00_00_01_00_00_01_01_0101, // R5 oc flag, ch0 blocked
    21'b000_00_00_00_00_00_01_01_1000, // R8 block persists
    21'b000_00_00_00_01_00_01_00_1000, // R8 request releases block
    21'b000_00_00_01_00_10_01_01_0101, // R5 oc beats clear
    21'b000_00_00_00_00_10_00_01_1000, // R8 clear leaves block
    21'b000_00_00_01_01_00_01_01_1000, // R8 oc with request keeps block
    21'b000_00_00_00_00_01_00_00_1001, // R9 restart clears flags and block
    21'b100_10_00_01_10_00_11_11_0001, // R1 mixed sources OR to 11
    21'b000_00_00_00_00_10_00_01_0011, // R3 all flags cleared, block remains
    21'b000_00_00_00_01_00_00_00_1000  // R8 release
  };

  task automatic drive(input logic [12:0] s);
    {pri_uv, pri_ov, pri_ot, sec_uv, sec_ov, oc_evt, pwm_req, flag_clr, restart} = s;
  endtask

  task automatic check(input logic [1:0] ec, input logic [NUM_CH-1:0] ei, input int req);
    checks++;
    if (flag_code !== ec || pwm_inhibit !== ei) begin
      bad++;
      $display("FAIL R%0d: code=%b inh=%b expected code=%b inh=%b",
               req, flag_code, pwm_inhibit, ec, ei);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(2'b00, 2'b00, 10); // R10 reset state
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][20:8]);
      @(posedge clk);
      #1;
      check(VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]));
    end

    // R11: no output change before the sampling edge
    @(negedge clk);
    drive(13'b100_00_00_00_00_00);
    #1;
    check(2'b00, 2'b00, 11);
    @(posedge clk);
    #1;
    check(2'b10, 2'b11, 11);

    // R10: reset mid-run wipes flags and block
    @(negedge clk);
    drive(13'b000_00_00_11_00_00);
    @(posedge clk);
    #1;
    check(2'b11, 2'b11, 1); // R1 held uv + oc on both channels
    @(negedge clk);
    drive('0);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(2'b00, 2'b00, 10);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(2'b00, 2'b00, 10);

    // R9: restart with a live primary condition keeps that flag
    @(negedge clk);
    drive(13'b001_00_00_00_00_01);
    @(posedge clk);
    #1;
    check(2'b11, 2'b11, 9);
    @(negedge clk);
    drive('0);
    @(posedge clk);
    #1;
    check(2'b11, 2'b00, 2); // R2 held after condition gone

    finish_run();
  end
endmodule